// File: doc/BRIEF.md
# Synchronous Burst SRAM Command Controller

This block is a cycle-level model of a synchronous burst SRAM with no wait states. It holds the command decoder, the operating state machine, the two-bit burst address counter and a small internal memory. On every rising clock edge it samples a three-pin chip select that mixes polarities, an advance/load strobe, write enable, one active-low write enable per byte lane, output enable and an active-low clock enable. From these inputs it moves to one of six phases: deselect, continue-deselect, begin read, burst read, begin write or burst write.

A new burst loads its address from the external address bus. Continue cycles then step only the two lowest address bits in linear order and wrap at the end. Write data is taken in the same cycle as the address it applies to. Read data is flow-through: it appears after the clock edge of its own address cycle and is gated by output enable. A write cycle in which every lane enable is inactive writes nothing, but it still counts as a write and still moves the burst forward.

Top module: `sbsram_ctrl`

## Requirements
- R1: While `cke_n` is high at a rising edge, the cycle is ignored. `phase`, the burst address, the memory contents and `rdata` all keep their values.
- R2: The device is selected only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. With `adv`=0 and any one enable inactive, the next phase is deselect. Reset also places the block in deselect, with `rd_en`=0.
- R3: With `adv`=1 in deselect or continue-deselect, the next phase is continue-deselect. Continue-deselect is never entered from a read or write phase.
- R4: When selected with `adv`=0 and `we_n`=1, the block enters begin-read at `addr`. If `oe_n`=0, the word at that address is driven in the same cycle.
- R5: A read cycle with `oe_n`=1 is a dummy read. The phase sequence is the same as for a real read, but `rd_en` stays 0.
- R6: With `adv`=1 after a read phase, the next phase is burst read at the next burst address. The chip enables, `we_n` and `addr` are ignored.
- R7: When selected with `adv`=0 and `we_n`=0, the block enters begin-write at `addr`. Only the lanes whose `bw_n` bit is 0 are written from `wdata`. Lane k occupies bits [9k+8:9k].
- R8: With `adv`=1 after a write phase, the next phase is burst write. The write lands at the next burst address: the low two bits count 0,1,2,3,0 and the upper bits stay fixed.
- R9: A begin-write or burst-write cycle with `bw_n`=4'b1111 writes no byte, yet its phase is still a write phase and the burst address still advances.
- R10: `rd_en` is 1 only in a read phase with `oe_n`=0. When `rd_en` is 0, `rdata` is zero, so the pad driver stays in high impedance.
- R11: `phase` encodes 0 deselect, 1 continue-deselect, 2 begin-read, 3 burst-read, 4 begin-write, 5 burst-write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke_n | input | 1 | Active-low clock enable; high freezes the cycle |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| adv | input | 1 | 1 = continue burst, 0 = load new command |
| we_n | input | 1 | Write enable, active low |
| bw_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 8 | External word address |
| wdata | input | 36 | Write data, four 9-bit lanes |
| rdata | output | 36 | Flow-through read data, zero when not driven |
| rd_en | output | 1 | Data pad drive enable |
| phase | output | 3 | Current operating phase (encoding in R11) |

## Verification
The hardest situation to reach is a write abort that falls partway through a burst. The only trace it leaves is the missing change in memory together with the counter having moved on, and neither is visible at the moment it happens. The stimulus writes a full wrapping burst and then issues an aborted continue cycle followed by a partial-lane write. Later read bursts that wrap across the same four words expose both effects. The same readback also shows that a write cycle frozen by the clock enable left memory untouched.

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cke_n,
  input  logic                      ce_a_n,
  input  logic                      ce_b,
  input  logic                      ce_c_n,
  input  logic                      adv,
  input  logic                      we_n,
  input  logic [LANES-1:0]          bw_n,
  input  logic                      oe_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      rd_en,
  output logic [2:0]                phase
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [2:0] {
    P_DESEL  = 3'd0,
    P_CDESEL = 3'd1,
    P_RD0    = 3'd2,
    P_RD     = 3'd3,
    P_WR0    = 3'd4,
    P_WR     = 3'd5
  } ph_t;

  ph_t               st, st_nx;
  logic [ADDR_W-1:0] cur, cur_nx, step_adr;
  logic              selected, in_rd, in_wr, wr_go;
  logic [DATA_W-1:0] mem [DEPTH];

  assign selected = !ce_a_n && ce_b && !ce_c_n;
  assign in_rd    = (st == P_RD0) || (st == P_RD);
  assign in_wr    = (st == P_WR0) || (st == P_WR);
  assign step_adr = {cur[ADDR_W-1:2], cur[1:0] + 2'd1};

  always_comb begin
    st_nx  = st;
    cur_nx = cur;
    wr_go  = 1'b0;
    if (!cke_n) begin
      if (!adv) begin
        if (selected) begin
          cur_nx = addr;
          if (we_n) begin
            st_nx = P_RD0;
          end else begin
            st_nx = P_WR0;
            wr_go = 1'b1;
          end
        end else begin
          st_nx = P_DESEL;
        end
      end else if (in_rd) begin
        st_nx  = P_RD;
        cur_nx = step_adr;
      end else if (in_wr) begin
        st_nx  = P_WR;
        cur_nx = step_adr;
        wr_go  = 1'b1;
      end else begin
        st_nx = P_CDESEL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= P_DESEL;
      cur <= '0;
    end else begin
      st  <= st_nx;
      cur <= cur_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) begin
      for (int l = 0; l < LANES; l++) begin
        if (!bw_n[l]) mem[cur_nx][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_en = in_rd && !oe_n;
  assign rdata = rd_en ? mem[cur] : '0;
  assign phase = st;

  assert_hold_on_cke_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(st) && $stable(cur)));

  assert_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv && !selected) |=> (st == P_DESEL));

  assert_cont_desel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv && (st == P_DESEL || st == P_CDESEL)) |=> (st == P_CDESEL));

  assert_no_cdesel_from_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv && (in_rd || in_wr)) |=> (st != P_CDESEL));

  assert_load_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv && selected) |=> (cur == $past(addr)));

  assert_burst_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv && (in_rd || in_wr)) |=>
      ((cur[1:0] == $past(cur[1:0]) + 2'd1) && (cur[ADDR_W-1:2] == $past(cur[ADDR_W-1:2]))));

  assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_rd && !oe_n) |-> (!rd_en && rdata == '0));

endmodule

// File: tb/sbsram_ctrl_tb.sv
module sbsram_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke_n = 1'b0, ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
  logic        adv = 1'b0, we_n = 1'b1, oe_n = 1'b1;
  logic [3:0]  bw_n = 4'hF;
  logic [7:0]  addr = '0;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic        rd_en;
  logic [2:0]  phase;

  int checks = 0;
  int errors = 0;

  logic [2:0]  m_ph = 3'd0;
  logic [7:0]  m_adr = '0;
  logic [35:0] ref_mem [256];

  logic [39:0] eq[$];
  string       tq[$];

  always #10 clk = ~clk;

  sbsram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce_a_n(ce_a_n), .ce_b(ce_b),
    .ce_c_n(ce_c_n), .adv(adv), .we_n(we_n), .bw_n(bw_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_en(rd_en), .phase(phase)
  );

  function automatic logic [7:0] nxt(input logic [7:0] a);
    return {a[7:2], a[1:0] + 2'd1};
  endfunction

  task automatic step(input string tag, input logic ck, input logic a_n, input logic b,
                      input logic c_n, input logic ad, input logic w_n, input logic [3:0] bw,
                      input logic o_n, input logic [7:0] ai, input logic [35:0] wd);
    logic sel, go, en;
    logic [35:0] d;
    @(negedge clk);
    cke_n = ck; ce_a_n = a_n; ce_b = b; ce_c_n = c_n; adv = ad;
    we_n = w_n; bw_n = bw; oe_n = o_n; addr = ai; wdata = wd;
    sel = !a_n && b && !c_n;
    go = 1'b0;
    if (!ck) begin
      if (!ad) begin
        if (sel) begin
          m_adr = ai;
          if (w_n) m_ph = 3'd2;
          else begin m_ph = 3'd4; go = 1'b1; end
        end else m_ph = 3'd0;
      end else if (m_ph == 3'd2 || m_ph == 3'd3) begin
        m_ph = 3'd3; m_adr = nxt(m_adr);
      end else if (m_ph == 3'd4 || m_ph == 3'd5) begin
        m_ph = 3'd5; m_adr = nxt(m_adr); go = 1'b1;
      end else m_ph = 3'd1;
    end
    if (go) for (int l = 0; l < 4; l++) if (!bw[l]) ref_mem[m_adr][l*9 +: 9] = wd[l*9 +: 9];
    en = (m_ph == 3'd2 || m_ph == 3'd3) && !o_n;
    d = en ? ref_mem[m_adr] : 36'd0;
    eq.push_back({m_ph, en, d});
    tq.push_back(tag);
  endtask

  logic [39:0] e_item;
  string       e_tag;
  always @(posedge clk) begin
    #5;
    if (eq.size() > 0) begin
      e_item = eq.pop_front();
      e_tag  = tq.pop_front();
      checks++;
      if (phase !== e_item[39:37] || rd_en !== e_item[36] || rdata !== e_item[35:0]) begin
        errors++;
        $display("FAIL %s: phase=%0d rd_en=%0b rdata=%h expected phase=%0d rd_en=%0b rdata=%h",
                 e_tag, phase, rd_en, rdata, e_item[39:37], e_item[36], e_item[35:0]);
      end
    end
  end

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (phase !== 3'd0 || rd_en !== 1'b0) begin
      errors++;
      $display("FAIL R2 reset: phase=%0d rd_en=%0b expected phase=0 rd_en=0", phase, rd_en);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R7 R11 begin write, then R8 burst write with ignored enables and address
    step("R7", 0, 0,1,0, 0, 0, 4'h0, 0, 8'h10, 36'h1_2345_6789);
    step("R8", 0, 1,0,1, 1, 1, 4'h0, 0, 8'hFF, 36'hA_BCDE_F012);
    step("R8", 0, 1,0,1, 1, 1, 4'h0, 1, 8'h00, 36'h5_5AA5_5AA5);
    step("R8", 0, 0,1,0, 1, 0, 4'h0, 0, 8'h77, 36'h0_F0F0_F0F0);
    // R9 abort mid-burst wraps to 0x10, R7 partial lanes at 0x11
    step("R9", 0, 0,1,0, 1, 0, 4'hF, 0, 8'h10, 36'hF_FFFF_FFFF);
    step("R7", 0, 0,1,0, 1, 0, 4'b1010, 0, 8'h10, 36'h3_3333_3333);
    // R2 each enable, R3 continue-deselect
    step("R2", 0, 1,1,0, 0, 1, 4'h0, 0, 8'h10, 36'h0);
    step("R3", 0, 0,1,0, 1, 0, 4'h0, 0, 8'h10, 36'h0);
    step("R3", 0, 0,1,0, 1, 1, 4'h0, 0, 8'h10, 36'h0);
    step("R2", 0, 0,0,0, 0, 1, 4'h0, 0, 8'h10, 36'h0);
    step("R2", 0, 0,1,1, 0, 0, 4'h0, 0, 8'h10, 36'h0);
    // R4 read, R6 continue with enables/we ignored, wrap
    step("R4", 0, 0,1,0, 0, 1, 4'h0, 0, 8'h10, 36'h0);
    step("R6", 0, 1,0,1, 1, 0, 4'h0, 0, 8'h40, 36'h7);
    step("R6", 0, 1,1,0, 1, 0, 4'h0, 0, 8'h40, 36'h7);
    step("R6", 0, 0,1,0, 1, 1, 4'h0, 0, 8'h40, 36'h7);
    step("R6", 0, 0,1,0, 1, 1, 4'h0, 0, 8'h40, 36'h7);
    // R1 clock enable freeze mid read
    step("R1", 1, 0,1,0, 0, 0, 4'h0, 0, 8'h13, 36'h9_9999_9999);
    step("R6", 0, 0,1,0, 1, 1, 4'h0, 0, 8'h40, 36'h0);
    // R5 dummy reads
    step("R5", 0, 0,1,0, 0, 1, 4'h0, 1, 8'h12, 36'h0);
    step("R5", 0, 0,1,0, 1, 1, 4'h0, 1, 8'h12, 36'h0);
    step("R10", 0, 0,1,0, 1, 1, 4'h0, 0, 8'h12, 36'h0);
    // R8 wrapping write from 0x22, R10 bus quiet during writes
    step("R8", 0, 0,1,0, 0, 0, 4'h0, 0, 8'h22, 36'h2_2222_2222);
    step("R8", 0, 0,1,0, 1, 0, 4'h0, 0, 8'h22, 36'h2_3232_3232);
    step("R8", 0, 0,1,0, 1, 0, 4'h0, 0, 8'h22, 36'h2_0202_0202);
    step("R1", 1, 0,1,0, 0, 0, 4'h0, 0, 8'h13, 36'hE_EEEE_EEEE);
    step("R10", 0, 0,1,0, 1, 0, 4'h0, 0, 8'h22, 36'h2_1212_1212);
    // R9 abort at begin-write over 0x13
    step("R9", 0, 0,1,0, 0, 0, 4'hF, 0, 8'h13, 36'hD_DDDD_DDDD);
    step("R9", 0, 0,1,0, 1, 0, 4'hF, 0, 8'h13, 36'hD_DDDD_DDDD);
    // readback
    step("R8", 0, 0,1,0, 0, 1, 4'h0, 0, 8'h22, 36'h0);
    for (int k = 0; k < 4; k++) step("R8", 0, 0,1,0, 1, 1, 4'h0, 0, 8'h0, 36'h0);
    step("R9", 0, 0,1,0, 0, 1, 4'h0, 0, 8'h13, 36'h0);
    for (int k = 0; k < 3; k++) step("R9", 0, 0,1,0, 1, 1, 4'h0, 0, 8'h0, 36'h0);
    step("R2", 0, 1,0,1, 0, 1, 4'h0, 0, 8'h0, 36'h0);
    repeat (3) @(posedge clk);
    #7;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule